// File: doc/BRIEF.md
# Real-Time Interval Clock

This block keeps a small free-running count of real-time ticks. A prescaler divides the system clock down to a tick strobe, nominally at 60 ticks per second. Each tick moves a 6-bit count forward by one. When the count rolls over from its top value back to zero, a sticky interval interrupt flag is set. In the same cycle a one-clock request pulse goes out to the interrupt prioritiser.

Software or a processor reads the flag and the count together as one 7-bit word. The flag stays set until a dedicated clear input removes it. A system clear zeroes the count and restarts the prescaler from the start of a tick period. It leaves the interrupt flag alone.

Top module: `rtc_interval_clock`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the count is 0, the interrupt flag is 0 and `intReq` is 0.
- R2: After reset or a system clear, the count first advances on the TICK_DIV-th rising clock edge. From then on it advances exactly once every TICK_DIV edges.
- R3: On a tick with the count below 63, the count increments by one. On a tick with the count equal to 63, the count becomes 0 and the interrupt flag is set.
- R4: `intReq` is high for exactly one clock: the first cycle in which the flag reads 1 after a wrap. It is low at all other times.
- R5: `readValue` carries the interrupt flag in bit 6 and the count in bits 5..0.
- R6: Once set, the flag stays set until `intClear` is high at a rising edge. After that edge it reads 0.
- R7: When `intClear` and a wrap fall on the same edge, the flag is 1 after that edge.
- R8: `sysClear` high at a rising edge makes the count 0 after that edge. It restarts the tick period so that the next advance comes TICK_DIV edges later. It does not change the flag.
- R9: On edges without a tick and without a system clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysClear | input | 1 | Zeroes the count and restarts the tick prescaler |
| intClear | input | 1 | Clears the sticky interval interrupt flag |
| readValue | output | 7 | Flag in bit 6, count in bits 5..0 |
| intReq | output | 1 | One-cycle interrupt request pulse on wrap |

## Verification
The bench builds the block with TICK_DIV set to 4 instead of the default of about two million. This puts a full 64-tick wrap within 256 clocks. Two wraps fit in a short run. The test can therefore exercise the rollover flag, the request pulse, and a clear that lands on the same edge as a wrap. It also brings within reach a system clear that lands mid-period, followed by a check of the restarted tick phase.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic advance;    // increment the count
    logic zeroCount;  // force the count to zero (wrap or system clear)
    logic setFlag;    // set the interval interrupt flag
    logic clrFlag;    // clear the interval interrupt flag
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_DIV = 2083333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      preCnt <= '0;
    end else if (preCnt == LAST) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign tick = (preCnt == LAST) && !restart;
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             tick,
  input  logic             sysClear,
  input  logic             intClear,
  input  logic [CNT_W-1:0] count,
  output rtcStrobes_t      strobes
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic atTop;
  assign atTop = (count == TOP);

  always_comb begin
    strobes = '0;
    if (sysClear) begin
      strobes.zeroCount = 1'b1;
    end else if (tick) begin
      if (atTop) begin
        strobes.zeroCount = 1'b1;
        strobes.setFlag   = 1'b1;
      end else begin
        strobes.advance   = 1'b1;
      end
    end
    // set wins over clear: a clear only takes effect without a wrap
    strobes.clrFlag = intClear && !strobes.setFlag;
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rtcStrobes_t      strobes,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             reqPulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (strobes.zeroCount) begin
      count <= '0;
    end else if (strobes.advance) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (strobes.setFlag) begin
      flag <= 1'b1;
    end else if (strobes.clrFlag) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqPulse <= 1'b0;
    end else begin
      reqPulse <= strobes.setFlag;
    end
  end
endmodule

// File: rtl/rtc_interval_clock.sv
module rtc_interval_clock
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 2083333,
  parameter int CNT_W    = 6,
  localparam int RD_W    = CNT_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sysClear,
  input  logic            intClear,
  output logic [RD_W-1:0] readValue,
  output logic            intReq
);
  logic             tickNow;
  logic [CNT_W-1:0] count;
  logic             flag;
  rtcStrobes_t      strobes;

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (sysClear),
    .tick    (tickNow)
  );

  rtc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .tick     (tickNow),
    .sysClear (sysClear),
    .intClear (intClear),
    .count    (count),
    .strobes  (strobes)
  );

  rtc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .count    (count),
    .flag     (flag),
    .reqPulse (intReq)
  );

  assign readValue = {flag, count};
endmodule

// File: rtl/rtc_interval_clock_chk.sv
module rtc_interval_clock_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sysClear,
  input logic             intClear,
  input logic             tick,
  input logic [CNT_W:0]   readValue,
  input logic             intReq
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             flg;
  assign cnt = readValue[CNT_W-1:0];
  assign flg = readValue[CNT_W];

  p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sysClear && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sysClear && cnt == TOP) |=> (cnt == '0 && flg));

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    intReq |=> !intReq);

  p_pulse_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg) |-> intReq);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flg && !intClear) |=> flg);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (intClear && !(tick && !sysClear && cnt == TOP)) |=> !flg);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (intClear && tick && !sysClear && cnt == TOP) |=> flg);

  p_sysclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sysClear |=> (cnt == '0 && flg == $past(flg)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sysClear) |=> $stable(cnt));
endmodule

bind rtc_interval_clock rtc_interval_clock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sysClear  (sysClear),
  .intClear  (intClear),
  .tick      (tickNow),
  .readValue (readValue),
  .intReq    (intReq)
);

// File: tb/sim_rtc_interval_clock.sv
module sim_rtc_interval_clock;
  localparam int DIV = 4;
  localparam int NV  = 8;
  // cumulative edges after reset release, expected count, expected flag
  localparam int V_EDGE[NV] = '{3, 4, 8, 9, 251, 252, 255, 256};
  localparam int V_CNT [NV] = '{0, 1, 2, 2, 62,  63,  63,  0};
  localparam int V_FLG [NV] = '{0, 0, 0, 0, 0,   0,   0,   1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sysClear = 1'b0;
  logic       intClear = 1'b0;
  logic [6:0] readValue;
  logic       intReq;

  int errors = 0;
  int checks = 0;
  int edges  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rtc_interval_clock #(.TICK_DIV(DIV), .CNT_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .sysClear(sysClear),
    .intClear(intClear), .readValue(readValue), .intReq(intReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", req, edges, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic stepTo(input int target);
    while (edges < target) step(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count+flag in reset", int'(readValue), 0);
    chk("R1 intReq in reset", int'(intReq), 0);
    rst_n = 1'b1;
    edges = 0;
    step(1);
    chk("R1 after release", int'(readValue), 0);

    // table walk: R2 period, R3 increment/wrap, R5 packing, R9 hold
    for (int v = 0; v < NV; v++) begin
      stepTo(V_EDGE[v]);
      chk("R2/R3/R5/R9 table", int'(readValue), (V_FLG[v] << 6) | V_CNT[v]);
    end
    chk("R4 pulse at wrap", int'(intReq), 1);
    step(1);
    chk("R4 pulse one cycle", int'(intReq), 0);
    stepTo(260);
    chk("R6 flag sticky", int'(readValue), 'h41);

    // clear flag
    intClear = 1'b1;
    step(1);
    intClear = 1'b0;
    chk("R6 clear", int'(readValue), 'h01);

    // clear coinciding with second wrap at edge 512
    stepTo(511);
    chk("R3 count at 63", int'(readValue), 'h3f);
    intClear = 1'b1;
    step(1);
    intClear = 1'b0;
    chk("R7 set wins over clear", int'(readValue), 'h40);
    chk("R4 pulse second wrap", int'(intReq), 1);

    // system clear mid-period with flag set
    sysClear = 1'b1;
    step(1);
    sysClear = 1'b0;
    chk("R8 count zero, flag kept", int'(readValue), 'h40);
    step(DIV - 1);
    chk("R8 no early tick", int'(readValue), 'h40);
    step(1);
    chk("R8 restarted period", int'(readValue), 'h41);
    chk("R4 no pulse without wrap", int'(intReq), 0);

    // reset again mid-run
    rst_n = 1'b0;
    step(1);
    rst_n = 1'b1;
    chk("R1 reset clears flag and count", int'(readValue), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule